// File: doc/BRIEF.md
# Expansion Card Memory Window Decoder

This block turns a 16-bit processor memory address into active-low chip selects for a plug-in expansion card. The card answers only inside the 8 KB window 0x4000–0x5FFF. Inside that window the lower 4 KB goes to a flash array and the upper 4 KB goes to an SRAM array. Optionally, the last 16 bytes of each half become a small register window for one of two peripherals. A card-level select also drives the host's bus-enable line.

Every output is purely combinational. The control bits come from an external bit register, which is not part of this block. One of them turns the card on. A second turns on the two register windows. A third blocks flash reads so that a multi-write unlock sequence is not broken up by the read the host issues before each write.

Some hosts drive five further page lines above the address. For those hosts, a mode input makes the card also require those lines to match a fixed page. The peripheral read strobes pass only in the lower eight bytes of each register window. The upper eight bytes are therefore write-only, and the dummy read before a write never reaches the peripheral.

Top module: `cardec_top`

## Requirements
- R1: All outputs are high (inactive) unless all of the following hold: `mem_en` is 1, `kill` is 0, `card_on` is 1, the address is in 0x4000–0x5FFF (`addr[15:13]` = 3'b010), and the page condition of R6 holds.
- R2: With `regwin_on` = 1 and the card hit, the selects map as follows:
  - `flash_sel_n` is low for 0x4000–0x4FEF.
  - `pera_sel_n` is low for 0x4FF0–0x4FFF.
  - `sram_sel_n` is low for 0x5000–0x5FEF.
  - `perb_sel_n` is low for 0x5FF0–0x5FFF.
- R3: With `regwin_on` = 0 and the card hit, `flash_sel_n` covers all of 0x4000–0x4FFF and `sram_sel_n` covers all of 0x5000–0x5FFF. Both peripheral selects and both read strobes stay high.
- R4: A peripheral read strobe (`pera_rd_n`, `perb_rd_n`) is low only under all of these conditions:
  - its select is low;
  - `is_read` is 1;
  - address bit 3 is 0, i.e. offsets 0x0–0x7.
  
  It stays high for writes and for offsets 0x8–0xF.
- R5: When `flash_rd_block` is 1 and `is_read` is 1, `flash_sel_n` stays high everywhere. Writes to flash are not affected by `flash_rd_block`.
- R6: With `page_mode` = 1, the card hits only when `page` equals 5'b10111, which together with `addr[15:13]` forms page 0xBA. With `page_mode` = 0, `page` has no effect.
- R7: `card_n` is low exactly when the card is hit per R1. This includes cycles where R5 suppresses the flash select.
- R8: At most one of the four region selects is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor memory address |
| mem_en | input | 1 | 1 during a memory cycle |
| is_read | input | 1 | 1 for a read cycle, 0 for a write |
| card_on | input | 1 | Card enable control bit |
| regwin_on | input | 1 | Register-window enable control bit |
| flash_rd_block | input | 1 | Blocks flash select during reads |
| page | input | 5 | Extra high page lines from the host |
| page_mode | input | 1 | 1 = require page match |
| kill | input | 1 | Master disable, 1 = card silent |
| card_n | output | 1 | Card select / bus enable, active low |
| flash_sel_n | output | 1 | Flash region select, active low |
| sram_sel_n | output | 1 | SRAM region select, active low |
| pera_sel_n | output | 1 | Peripheral A window select, active low |
| perb_sel_n | output | 1 | Peripheral B window select, active low |
| pera_rd_n | output | 1 | Gated read strobe for peripheral A |
| perb_rd_n | output | 1 | Gated read strobe for peripheral B |

## Verification
The bench builds the decoder with its default parameters: a 16-bit address, a 5-bit page matched against 5'b10111, and 16-byte register windows. These defaults place every boundary at the exact addresses named in the requirements: 0x3FFF/0x4000, 0x4FEF/0x4FF0, 0x4FF7/0x4FF8, 0x5FFF/0x6000.

All 32 combinations of card enable, window enable, read block, page mode and direction are walked. Each walk covers a strided sweep of the full address space plus every address around these edges. Separate passes walk all 32 page values, as well as the memory-enable and master-disable gating.

// File: rtl/cardec_pkg.sv
// Shared types for the expansion card decoder.
// Assumes region codes are ordered low half, low register window,
// high half, high register window.
package cardec_pkg;
    typedef enum logic [1:0] {
        RGN_MEM_LO = 2'd0,
        RGN_REG_LO = 2'd1,
        RGN_MEM_HI = 2'd2,
        RGN_REG_HI = 2'd3
    } region_e;

    localparam int unsigned NUM_RGN = 4;
    localparam int unsigned NUM_PER = 2;
endpackage

// File: rtl/cardec_window.sv
// Card window hit detection: decides whether the current memory cycle
// addresses this card at all.
// Assumes the window is the top TAG_W address bits equal to WIN_TAG, and
// that the page lines are only meaningful when page_mode is set.
module cardec_window #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned TAG_W      = 3,
    parameter logic [TAG_W-1:0] WIN_TAG = 3'b010,
    parameter int unsigned PAGE_W     = 5,
    parameter logic [PAGE_W-1:0] PAGE_MATCH = 5'b10111
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_en,
    input  logic              card_on,
    input  logic              kill,
    input  logic [PAGE_W-1:0] page,
    input  logic              page_mode,
    output logic              hit
);
    logic tag_ok;
    logic page_ok;

    // Compare the top address bits against the window tag.
    always_comb begin
        tag_ok = (addr[ADDR_W-1 -: TAG_W] == WIN_TAG);
    end

    // Page lines matter only in second-host mode.
    always_comb begin
        page_ok = !page_mode || (page == PAGE_MATCH);
    end

    // Combine the cycle qualifiers into a single hit.
    always_comb begin
        hit = mem_en && !kill && card_on && tag_ok && page_ok;
    end
endmodule

// File: rtl/cardec_region.sv
// Splits the card window into four regions: two memory halves, each with
// an optional register window of 2**REG_LSB bytes at its top.
// Assumes the half is chosen by the bit just below the window tag.
module cardec_region
    import cardec_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned TAG_W   = 3,
    parameter int unsigned REG_LSB = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              regwin_on,
    output region_e           region
);
    localparam int unsigned HALF_BIT = ADDR_W - TAG_W - 1;
    localparam int unsigned FLD_MSB  = HALF_BIT - 1;

    logic upper_half;
    logic in_regwin;

    // Select which memory half the address falls in.
    always_comb begin
        upper_half = addr[HALF_BIT];
    end

    // Register window: all offset bits above the window size are ones.
    always_comb begin
        in_regwin = regwin_on && (&addr[FLD_MSB:REG_LSB]);
    end

    // Encode the region.
    always_comb begin
        unique case ({upper_half, in_regwin})
            2'b00:   region = RGN_MEM_LO;
            2'b01:   region = RGN_REG_LO;
            2'b10:   region = RGN_MEM_HI;
            default: region = RGN_REG_HI;
        endcase
    end
endmodule

// File: rtl/cardec_rdgate.sv
// Read strobe gate for one register window: lets a read through only in
// the lower half of the window so that upper offsets are write-only.
// Assumes sel_n is the already-decoded active-low window select.
module cardec_rdgate #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned REG_LSB = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              is_read,
    output logic              rd_n
);
    localparam int unsigned WO_BIT = REG_LSB - 1;

    // Pass the read only for selected, read, lower-half offsets.
    always_comb begin
        rd_n = !(!sel_n && is_read && !addr[WO_BIT]);
    end
endmodule

// File: rtl/cardec_top.sv
// Expansion card address decoder top. Combinational: produces the
// card-select/bus-enable and per-region active-low selects, plus gated
// peripheral read strobes.
// Assumes control bits are held stable by an external register and that
// the outputs are sampled only after the address has settled.
module cardec_top
    import cardec_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned PAGE_W  = 5,
    parameter logic [PAGE_W-1:0] PAGE_MATCH = 5'b10111,
    parameter int unsigned REG_LSB = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_en,
    input  logic              is_read,
    input  logic              card_on,
    input  logic              regwin_on,
    input  logic              flash_rd_block,
    input  logic [PAGE_W-1:0] page,
    input  logic              page_mode,
    input  logic              kill,
    output logic              card_n,
    output logic              flash_sel_n,
    output logic              sram_sel_n,
    output logic              pera_sel_n,
    output logic              perb_sel_n,
    output logic              pera_rd_n,
    output logic              perb_rd_n
);
    localparam int unsigned TAG_W = 3;
    localparam logic [TAG_W-1:0] WIN_TAG = 3'b010;

    logic                 hit;
    region_e              region;
    logic [NUM_RGN-1:0]   rgn_sel;
    logic [NUM_PER-1:0]   per_sel_n;
    logic [NUM_PER-1:0]   per_rd_n;

    cardec_window #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W), .WIN_TAG(WIN_TAG),
        .PAGE_W(PAGE_W), .PAGE_MATCH(PAGE_MATCH)
    ) u_window (
        .addr(addr), .mem_en(mem_en), .card_on(card_on), .kill(kill),
        .page(page), .page_mode(page_mode), .hit(hit)
    );

    cardec_region #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W), .REG_LSB(REG_LSB)
    ) u_region (
        .addr(addr), .regwin_on(regwin_on), .region(region)
    );

    // One select line per region code, qualified by the window hit.
    for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
        always_comb begin
            rgn_sel[r] = hit && (region == region_e'(r));
        end
    end

    // Peripheral windows sit at region codes 1 and 3; each gets a read gate.
    for (genvar p = 0; p < NUM_PER; p++) begin : g_per
        always_comb begin
            per_sel_n[p] = !rgn_sel[2*p + 1];
        end
        cardec_rdgate #(.ADDR_W(ADDR_W), .REG_LSB(REG_LSB)) u_rdgate (
            .addr(addr), .sel_n(per_sel_n[p]), .is_read(is_read),
            .rd_n(per_rd_n[p])
        );
    end

    // Drive the card-level and memory-region outputs.
    always_comb begin
        card_n      = !hit;
        flash_sel_n = !(rgn_sel[RGN_MEM_LO] && !(is_read && flash_rd_block));
        sram_sel_n  = !rgn_sel[RGN_MEM_HI];
        pera_sel_n  = per_sel_n[0];
        perb_sel_n  = per_sel_n[1];
        pera_rd_n   = per_rd_n[0];
        perb_rd_n   = per_rd_n[1];
    end
endmodule

// File: rtl/cardec_top_chk.sv
// Property checker for cardec_top, attached by bind. Immediate checks on
// the settled combinational outputs.
module cardec_top_chk (
    input logic        mem_en,
    input logic        is_read,
    input logic        kill,
    input logic        flash_rd_block,
    input logic        card_n,
    input logic        flash_sel_n,
    input logic        sram_sel_n,
    input logic        pera_sel_n,
    input logic        perb_sel_n,
    input logic        pera_rd_n,
    input logic        perb_rd_n
);
    logic [3:0] sel_act;

    // Gather active region selects.
    always_comb begin
        sel_act = ~{flash_sel_n, sram_sel_n, pera_sel_n, perb_sel_n};
    end

    // Check output relations whenever inputs or outputs move.
    always_comb begin
        a_r8_one_region: assert ($onehot0(sel_act))
            else $error("R8 more than one region select active");
        a_r1_idle_quiet: assert (mem_en && !kill || (card_n && sel_act == 4'b0))
            else $error("R1 output active while idle or disabled");
        a_r7_card_covers: assert (sel_act == 4'b0 || !card_n)
            else $error("R7 region select without card select");
        a_r4_no_write_rd: assert (is_read || (pera_rd_n && perb_rd_n))
            else $error("R4 read strobe during write");
        a_r4_rd_needs_sel: assert ((pera_rd_n || !pera_sel_n) && (perb_rd_n || !perb_sel_n))
            else $error("R4 read strobe without its select");
        a_r5_flash_blocked: assert (!(is_read && flash_rd_block) || flash_sel_n)
            else $error("R5 flash selected on blocked read");
    end
endmodule

bind cardec_top cardec_top_chk u_chk (
    .mem_en(mem_en), .is_read(is_read), .kill(kill),
    .flash_rd_block(flash_rd_block), .card_n(card_n),
    .flash_sel_n(flash_sel_n), .sram_sel_n(sram_sel_n),
    .pera_sel_n(pera_sel_n), .perb_sel_n(perb_sel_n),
    .pera_rd_n(pera_rd_n), .perb_rd_n(perb_rd_n)
);

// File: tb/tb_cardec_top.sv
// Self-checking bench: drives on the rising edge, compares against a
// behavioural model on the falling edge.
module tb_cardec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        mem_en = 1'b0, is_read = 1'b0, card_on = 1'b0, regwin_on = 1'b0;
    logic        flash_rd_block = 1'b0, page_mode = 1'b0, kill = 1'b0;
    logic [4:0]  page = '0;
    logic        card_n, flash_sel_n, sram_sel_n, pera_sel_n, perb_sel_n;
    logic        pera_rd_n, perb_rd_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cardec_top dut (
        .addr(addr), .mem_en(mem_en), .is_read(is_read), .card_on(card_on),
        .regwin_on(regwin_on), .flash_rd_block(flash_rd_block), .page(page),
        .page_mode(page_mode), .kill(kill), .card_n(card_n),
        .flash_sel_n(flash_sel_n), .sram_sel_n(sram_sel_n),
        .pera_sel_n(pera_sel_n), .perb_sel_n(perb_sel_n),
        .pera_rd_n(pera_rd_n), .perb_rd_n(perb_rd_n)
    );

    // Behavioural model of the requirements; returns
    // {card, flash, sram, pera, perb, pera_rd, perb_rd}, active low.
    function automatic logic [6:0] model();
        int  a = int'(addr);
        bit  hit, inreg, lo, pa, pb, fl, sr;
        hit = mem_en && !kill && card_on && a >= 'h4000 && a <= 'h5FFF
              && (!page_mode || page == 5'd23);
        inreg = regwin_on && ((a & 'h0FF0) == 'h0FF0);
        lo = a < 'h5000;
        fl = hit && lo && !inreg && !(is_read && flash_rd_block);
        sr = hit && !lo && !inreg;
        pa = hit && lo && inreg;
        pb = hit && !lo && inreg;
        return ~{hit, fl, sr, pa, pb,
                 pa && is_read && (a & 8) == 0,
                 pb && is_read && (a & 8) == 0};
    endfunction

    // Pick the requirement a mismatch belongs to.
    function automatic string tag_of(logic [6:0] diff);
        if (!mem_en || kill || !card_on) return "R1";
        if (page_mode && page != 5'd23) return "R6";
        if (diff[6]) return "R7";
        if (diff[1:0] != 0) return "R4";
        if (diff[5] && is_read && flash_rd_block) return "R5";
        return regwin_on ? "R2" : "R3";
    endfunction

    task automatic apply(input logic [15:0] a);
        logic [6:0] got, exp;
        @(posedge clk);
        addr = a;
        @(negedge clk);
        got = {card_n, flash_sel_n, sram_sel_n, pera_sel_n, perb_sel_n,
               pera_rd_n, perb_rd_n};
        exp = model();
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h ctl=%b%b%b%b%b%b%b page=%h got=%b exp=%b",
                     tag_of(got ^ exp), a, mem_en, kill, card_on, regwin_on,
                     flash_rd_block, page_mode, is_read, page, got, exp);
        end
    endtask

    task automatic edges();
        apply(16'h3FFF); apply(16'h4000); apply(16'h4FEF); apply(16'h5000);
        apply(16'h5FEF); apply(16'h5FFF); apply(16'h6000); apply(16'hC000);
        for (int i = 0; i < 32; i++) begin
            apply(16'h4FE0 + 16'(i));
            apply(16'h5FE0 + 16'(i));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset/idle state, R1: mem_en low keeps everything quiet.
        apply(16'h4000);
        apply(16'h5FF0);
        // Main sweep: R2 R3 R4 R5 R6 R7 R8 over all 32 control mixes.
        mem_en = 1'b1;
        page = 5'd23;
        for (int c = 0; c < 32; c++) begin
            {card_on, regwin_on, flash_rd_block, page_mode, is_read} = 5'(c);
            for (int a = 0; a < 65536; a += 37) apply(16'(a));
            edges();
        end
        // R6: every page value, both modes.
        card_on = 1'b1; regwin_on = 1'b1; flash_rd_block = 1'b0;
        for (int m = 0; m < 2; m++) begin
            page_mode = m[0];
            for (int p = 0; p < 32; p++) begin
                page = 5'(p);
                is_read = p[0];
                apply(16'h4100); apply(16'h4FF2); apply(16'h5A00); apply(16'h5FF9);
            end
        end
        // R1: master disable and memory-enable gating.
        page = 5'd23; page_mode = 1'b0; is_read = 1'b1;
        kill = 1'b1;
        for (int a = 0; a < 65536; a += 101) apply(16'(a));
        edges();
        kill = 1'b0; mem_en = 1'b0;
        for (int a = 0; a < 65536; a += 101) apply(16'(a));
        edges();
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got=hung exp=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule